// File: doc/BRIEF.md
# Bank Activation Timing Guard

This block sits beside the command bus of an eight-bank DDR2-style memory controller. It watches the raw command strobes and decodes them. For every bank it keeps an open/closed flag, the row that was last opened, and a set of small down-counters. From these it reports, for each bank and in the current cycle, whether an activate, a column access (read or write) or a precharge would be legal. A scheduler can use those vectors as gates. A test harness can use the same vectors as a protocol monitor.

Every timing value is a static clock count on a configuration input. The guard enforces four delays for each bank: activate to column access, with additive latency subtracted; activate to precharge; precharge to activate; and activate to activate on the same bank. It also enforces two limits across all banks: the minimum gap between any two activates, and a rolling window that admits at most four activates. A precharge-all command lengthens the precharge wait by one cycle.

A command that breaks a rule still updates the tracked state. It also raises a sticky violation flag and records the bank that caused it. Only reset clears the flag.

Top module: `act_timing_guard`

## Requirements
- R1: While reset is held and after its release, every bank reads closed: `act_ok` is all ones, `rw_ok` and `pre_ok` are all zeros, `open_rows` is zero and `viol` is low.
- R2: Commands are decoded only when `cs_n` is low, from {`ras_n`,`cas_n`,`we_n`}: 011 is an activate, 101 a read, 100 a write, and 010 a precharge. For a precharge, `addr[10]` set means all banks and clear means the bank on `bank_sel`. Any other code, or `cs_n` high, changes no state and no output.
- R3: `act_ok[b]` is high only when all of these hold: bank b is closed; at least `cfg_trc` cycles have passed since the last activate of b; at least `cfg_trp` cycles have passed since the last precharge of b (`cfg_trp`+1 if that precharge was a precharge-all); and at least `cfg_trrd` cycles have passed since an activate to any bank.
- R4: An activate is allowed only when fewer than four activates were issued in the previous `cfg_tfaw`-1 cycles. With a window of 10 and an activate in cycle N, at most three more fit in cycles N+1 to N+9.
- R5: `rw_ok[b]` is high when bank b is open and the cycles elapsed since its activate are at least the larger of 1 and `cfg_trcd`-`cfg_al`.
- R6: `pre_ok[b]` is high when bank b is open and at least `cfg_tras` cycles have passed since its activate.
- R7: A precharge-all closes every bank, and each bank's precharge wait becomes `cfg_trp`+1 cycles. A single precharge closes only its bank and starts a `cfg_trp` wait on that bank, even if the bank was already closed.
- R8: An activate stores `addr` as the row of the selected bank, visible on `open_rows[b*14 +: 14]` from the next cycle. Reads and writes never close a bank.
- R9: A command that is not allowed in its cycle sets `viol` and loads `viol_bank` in the next cycle. Not allowed means: an activate with `act_ok` low, a read or write with `rw_ok` low, or a precharge with `pre_ok` low. A precharge-all is not allowed when any open bank has `pre_ok` low, and in that case the lowest such bank is recorded. The flag and the bank hold until reset, and later violations do not overwrite them.
- R10: A disallowed command updates bank state and timers exactly as an allowed one would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| bank_sel | input | 3 | Bank address |
| addr | input | 14 | Row address; bit 10 selects all banks on a precharge |
| cfg_trcd | input | 6 | Activate to column access, cycles |
| cfg_tras | input | 6 | Activate to precharge, cycles |
| cfg_trp | input | 6 | Precharge to activate, cycles |
| cfg_trc | input | 6 | Activate to activate on the same bank, cycles |
| cfg_trrd | input | 6 | Activate to activate on any bank, cycles |
| cfg_tfaw | input | 6 | Four-activate window length, cycles, pre-rounded |
| cfg_al | input | 3 | Additive latency, 0 to 4 |
| act_ok | output | 8 | Activate allowed, per bank |
| rw_ok | output | 8 | Read or write allowed, per bank |
| pre_ok | output | 8 | Precharge allowed, per bank |
| open_rows | output | 112 | Stored row of each bank, 14 bits each, bank 0 lowest |
| viol | output | 1 | Sticky violation flag |
| viol_bank | output | 3 | Bank of the first violation |

## Verification
The hardest collision is an activate that arrives in the same cycle as the oldest entry leaves the four-activate window, often while the same-bank or any-bank activate gap also runs out. The stimulus sets a window of 10 and a short activate gap, issues four back-to-back activates, and then walks single cycles up to the window edge. A bench model built from timestamps judges `act_ok` in every one of those cycles. Random traffic with a short window and a spread of additive latencies produces many more of these coincidences. A second collision, a precharge-all that meets an open bank whose `cfg_tras` has not yet run out, is provoked directly and judged by the recorded bank.

// File: rtl/act_guard_pkg.sv
package act_guard_pkg;

   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_WR   = 3'd3,
      CMD_PRE  = 3'd4,
      CMD_PREA = 3'd5
   } gcmd_e;

   // Strobe decode; a10 widens a precharge to every bank.
   function automatic gcmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n,
                                        input logic a10);
      gcmd_e c;
      c = CMD_NOP;
      if (!cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b011:  c = CMD_ACT;
            3'b101:  c = CMD_RD;
            3'b100:  c = CMD_WR;
            3'b010:  c = a10 ? CMD_PREA : CMD_PRE;
            default: c = CMD_NOP;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/guard_countdown.sv
module guard_countdown #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/guard_bank.sv
module guard_bank #(
   parameter int W   = 6,
   parameter int RAW = 14
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           act_ev,
   input  logic           pre_ev,
   input  logic           pre_all,
   input  logic [W-1:0]   rcd_ld,
   input  logic [W-1:0]   ras_ld,
   input  logic [W-1:0]   rc_ld,
   input  logic [W-1:0]   rp_ld,
   input  logic [W-1:0]   rpa_ld,
   input  logic [RAW-1:0] row_in,
   output logic           is_open,
   output logic           rcd_done,
   output logic           ras_done,
   output logic           rc_done,
   output logic           rp_done,
   output logic [RAW-1:0] row_out
);
   logic [RAW-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         row_q   <= '0;
      end else if (act_ev) begin
         is_open <= 1'b1;
         row_q   <= row_in;
      end else if (pre_ev) begin
         is_open <= 1'b0;
      end
   end
   assign row_out = row_q;

   guard_countdown #(.W(W)) u_rcd (.clk(clk), .rst_n(rst_n), .load(act_ev),
                                   .load_val(rcd_ld), .done(rcd_done));
   guard_countdown #(.W(W)) u_ras (.clk(clk), .rst_n(rst_n), .load(act_ev),
                                   .load_val(ras_ld), .done(ras_done));
   guard_countdown #(.W(W)) u_rc  (.clk(clk), .rst_n(rst_n), .load(act_ev),
                                   .load_val(rc_ld),  .done(rc_done));
   guard_countdown #(.W(W)) u_rp  (.clk(clk), .rst_n(rst_n), .load(pre_ev),
                                   .load_val(pre_all ? rpa_ld : rp_ld), .done(rp_done));
endmodule

// File: rtl/guard_faw.sv
module guard_faw #(
   parameter int SLOTS = 4,
   parameter int W     = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         act,
   input  logic [W-1:0] win_ld,
   output logic         ok
);
   localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam int CW = $clog2(SLOTS + 1);

   logic [W-1:0]  slot [SLOTS];
   logic [IW-1:0] victim;
   logic [CW-1:0] busy;

   // Oldest entry (smallest remaining time) is replaced, so the slots
   // always hold the most recent activates.
   always_comb begin
      victim = '0;
      busy   = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (slot[i] < slot[victim]) victim = IW'(i);
         if (slot[i] != '0)          busy   = busy + 1'b1;
      end
   end

   assign ok = (busy < CW'(SLOTS));

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           slot[i] <= '0;
         else if (act && victim == IW'(i))     slot[i] <= win_ld;
         else if (slot[i] != '0)               slot[i] <= slot[i] - 1'b1;
      end
   end
endmodule

// File: rtl/act_timing_guard.sv
module act_timing_guard
   import act_guard_pkg::*;
#(
   parameter int NB      = 8,
   parameter int RAW     = 14,
   parameter int TW      = 6,
   parameter int ALW     = 3,
   parameter int MAX_ACT = 4,
   localparam int BAW    = $clog2(NB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BAW-1:0]    bank_sel,
   input  logic [RAW-1:0]    addr,
   input  logic [TW-1:0]     cfg_trcd,
   input  logic [TW-1:0]     cfg_tras,
   input  logic [TW-1:0]     cfg_trp,
   input  logic [TW-1:0]     cfg_trc,
   input  logic [TW-1:0]     cfg_trrd,
   input  logic [TW-1:0]     cfg_tfaw,
   input  logic [ALW-1:0]    cfg_al,
   output logic [NB-1:0]     act_ok,
   output logic [NB-1:0]     rw_ok,
   output logic [NB-1:0]     pre_ok,
   output logic [NB*RAW-1:0] open_rows,
   output logic              viol,
   output logic [BAW-1:0]    viol_bank
);
   if (NB < 2 || (NB & (NB - 1)) != 0) begin : g_bad_nb
      $error("act_timing_guard: NB must be a power of two of at least 2");
   end
   if (RAW < 11) begin : g_bad_raw
      $error("act_timing_guard: RAW must reach address bit 10");
   end
   if (MAX_ACT < 1 || TW < 2 || ALW > TW) begin : g_bad_cnt
      $error("act_timing_guard: MAX_ACT, TW or ALW out of range");
   end

   function automatic logic [TW-1:0] less1(input logic [TW-1:0] v);
      return (v == '0) ? '0 : v - 1'b1;
   endfunction

   gcmd_e cmd;
   assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n, addr[10]);

   // Column-access wait shrinks by the additive latency, never below one cycle.
   logic [TW:0]   trcd_w, al_p1;
   logic [TW-1:0] rcd_ld;
   always_comb begin
      trcd_w = {1'b0, cfg_trcd};
      al_p1  = (TW+1)'(cfg_al) + {{TW{1'b0}}, 1'b1};
      rcd_ld = (trcd_w > al_p1) ? TW'(trcd_w - al_p1) : '0;
   end

   logic          is_act;
   logic          rrd_done, faw_ok;
   logic [NB-1:0] bank_open, rcd_done, ras_done, rc_done, rp_done;

   assign is_act = (cmd == CMD_ACT);

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic hit;
      assign hit = (bank_sel == BAW'(b));
      guard_bank #(.W(TW), .RAW(RAW)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .act_ev(is_act && hit),
         .pre_ev((cmd == CMD_PRE && hit) || cmd == CMD_PREA),
         .pre_all(cmd == CMD_PREA),
         .rcd_ld(rcd_ld), .ras_ld(less1(cfg_tras)), .rc_ld(less1(cfg_trc)),
         .rp_ld(less1(cfg_trp)), .rpa_ld(cfg_trp),
         .row_in(addr),
         .is_open(bank_open[b]), .rcd_done(rcd_done[b]), .ras_done(ras_done[b]),
         .rc_done(rc_done[b]), .rp_done(rp_done[b]),
         .row_out(open_rows[b*RAW +: RAW]));
      assign act_ok[b] = !bank_open[b] && rc_done[b] && rp_done[b] && rrd_done && faw_ok;
      assign rw_ok[b]  = bank_open[b] && rcd_done[b];
      assign pre_ok[b] = bank_open[b] && ras_done[b];
   end

   guard_countdown #(.W(TW)) u_rrd (.clk(clk), .rst_n(rst_n), .load(is_act),
                                    .load_val(less1(cfg_trrd)), .done(rrd_done));

   guard_faw #(.SLOTS(MAX_ACT), .W(TW)) u_faw (.clk(clk), .rst_n(rst_n), .act(is_act),
                                               .win_ld(less1(cfg_tfaw)), .ok(faw_ok));

   logic           bad;
   logic [BAW-1:0] bad_bank;
   always_comb begin
      bad      = 1'b0;
      bad_bank = bank_sel;
      case (cmd)
         CMD_ACT:         bad = !act_ok[bank_sel];
         CMD_RD, CMD_WR:  bad = !rw_ok[bank_sel];
         CMD_PRE:         bad = !pre_ok[bank_sel];
         CMD_PREA: begin
            for (int b = NB - 1; b >= 0; b--) begin
               if (bank_open[b] && !ras_done[b]) begin
                  bad      = 1'b1;
                  bad_bank = BAW'(b);
               end
            end
         end
         default: bad = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol      <= 1'b0;
         viol_bank <= '0;
      end else if (!viol && bad) begin
         viol      <= 1'b1;
         viol_bank <= bad_bank;
      end
   end
endmodule

// File: rtl/act_guard_chk.sv
module act_guard_chk #(
   parameter int NB  = 8,
   parameter int RAW = 14,
   parameter int BAW = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic              a10,
   input logic [BAW-1:0]    bank_sel,
   input logic [NB-1:0]     act_ok,
   input logic [NB-1:0]     rw_ok,
   input logic [NB-1:0]     pre_ok,
   input logic [NB*RAW-1:0] open_rows,
   input logic              viol,
   input logic [BAW-1:0]    viol_bank
);
   logic saw_act, saw_prea;
   assign saw_act  = !cs_n && !ras_n && cas_n && we_n;
   assign saw_prea = !cs_n && !ras_n && cas_n && !we_n && a10;

   // R9
   viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol |=> viol);

   // R9
   viol_bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol |=> $stable(viol_bank));

   // R3
   act_blocks_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      saw_act |=> !act_ok[$past(bank_sel)]);

   // R7
   preall_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      saw_prea |=> (rw_ok == '0 && pre_ok == '0));

   // R2
   deselect_no_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> $stable(open_rows));
endmodule

bind act_timing_guard act_guard_chk #(.NB(NB), .RAW(RAW), .BAW(BAW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
   .we_n(we_n), .a10(addr[10]), .bank_sel(bank_sel), .act_ok(act_ok),
   .rw_ok(rw_ok), .pre_ok(pre_ok), .open_rows(open_rows), .viol(viol),
   .viol_bank(viol_bank));

// File: tb/sim_act_timing_guard.sv
`timescale 1ns/1ps
module sim_act_timing_guard;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [2:0]  bank_sel = '0;
   logic [13:0] addr = '0;
   logic [5:0]  cfg_trcd, cfg_tras, cfg_trp, cfg_trc, cfg_trrd, cfg_tfaw;
   logic [2:0]  cfg_al;
   logic [7:0]  act_ok, rw_ok, pre_ok;
   logic [111:0] open_rows;
   logic        viol;
   logic [2:0]  viol_bank;

   always #5 clk = ~clk;

   act_timing_guard u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .bank_sel(bank_sel), .addr(addr),
      .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
      .cfg_trc(cfg_trc), .cfg_trrd(cfg_trrd), .cfg_tfaw(cfg_tfaw), .cfg_al(cfg_al),
      .act_ok(act_ok), .rw_ok(rw_ok), .pre_ok(pre_ok), .open_rows(open_rows),
      .viol(viol), .viol_bank(viol_bank));

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   // Timestamp model of the rules.
   int t, trcd, tras, trp, trc, trrd, tfaw, al;
   int last_act [8], last_pre [8], hist [4], last_any;
   bit mopen [8], prall [8];
   logic [13:0] mrow [8];
   bit mviol; int mvb;

   function automatic bit m_act_ok(int b);
      int nrec = 0;
      for (int i = 0; i < 4; i++) if (t - hist[i] < tfaw) nrec++;
      return !mopen[b] && (t - last_pre[b] >= trp + int'(prall[b])) &&
             (t - last_act[b] >= trc) && (t - last_any >= trrd) && nrec < 4;
   endfunction
   function automatic bit m_rw_ok(int b);
      int need = trcd - al;
      if (need < 1) need = 1;
      return mopen[b] && (t - last_act[b] >= need);
   endfunction
   function automatic bit m_pre_ok(int b);
      return mopen[b] && (t - last_act[b] >= tras);
   endfunction
   function automatic int m_prea_bad();
      for (int b = 0; b < 8; b++) if (mopen[b] && !m_pre_ok(b)) return b;
      return -1;
   endfunction

   task automatic cmp(string tag, logic [127:0] act, logic [127:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, t, act, exp);
      end
   endtask

   task automatic check_outs();
      logic [7:0] ea, er, ep; logic [111:0] erow;
      for (int b = 0; b < 8; b++) begin
         ea[b] = m_act_ok(b); er[b] = m_rw_ok(b); ep[b] = m_pre_ok(b);
         erow[b*14 +: 14] = mrow[b];
      end
      cmp("R3/R4 act_ok", 128'(act_ok), 128'(ea));
      cmp("R5 rw_ok", 128'(rw_ok), 128'(er));
      cmp("R6 pre_ok", 128'(pre_ok), 128'(ep));
      cmp("R8 open_rows", 128'(open_rows), 128'(erow));
      cmp("R9 viol", 128'({viol, viol ? viol_bank : 3'd0}),
          128'({mviol, mviol ? 3'(mvb) : 3'd0}));
   endtask

   // kind: 0 nop, 1 act, 2 rd, 3 wr, 4 pre, 5 pre-all, 6 refresh code, 7 deselected act
   task automatic apply(int kind, int b, logic [13:0] row);
      bit bad = 0; int bb = b;
      @(negedge clk);
      check_outs();
      bank_sel = 3'(b); addr = row; cs_n = 1'b0;
      case (kind)
         1: {ras_n, cas_n, we_n} = 3'b011;
         2: {ras_n, cas_n, we_n} = 3'b101;
         3: {ras_n, cas_n, we_n} = 3'b100;
         4: begin {ras_n, cas_n, we_n} = 3'b010; addr[10] = 1'b0; end
         5: begin {ras_n, cas_n, we_n} = 3'b010; addr[10] = 1'b1; end
         6: {ras_n, cas_n, we_n} = 3'b001;
         7: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b011; end
         default: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; end
      endcase
      case (kind)
         1: begin
            bad = !m_act_ok(b);
            mopen[b] = 1; mrow[b] = addr; last_act[b] = t; last_any = t;
            for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = t;
         end
         2, 3: bad = !m_rw_ok(b);
         4: begin bad = !m_pre_ok(b); mopen[b] = 0; last_pre[b] = t; prall[b] = 0; end
         5: begin
            bb = m_prea_bad(); bad = (bb >= 0);
            for (int k = 0; k < 8; k++) begin mopen[k] = 0; last_pre[k] = t; prall[k] = 1; end
         end
         default: ;
      endcase
      if (bad && !mviol) begin mviol = 1; mvb = bb; end
      t++;
   endtask

   task automatic do_reset(int c_rcd, int c_ras, int c_rp, int c_rc, int c_rrd, int c_faw, int c_al);
      trcd = c_rcd; tras = c_ras; trp = c_rp; trc = c_rc; trrd = c_rrd; tfaw = c_faw; al = c_al;
      cfg_trcd = 6'(c_rcd); cfg_tras = 6'(c_ras); cfg_trp = 6'(c_rp); cfg_trc = 6'(c_rc);
      cfg_trrd = 6'(c_rrd); cfg_tfaw = 6'(c_faw); cfg_al = 3'(c_al);
      cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
      rst_n = 1'b0;
      for (int b = 0; b < 8; b++) begin
         last_act[b] = -1000; last_pre[b] = -1000; mopen[b] = 0; prall[b] = 0; mrow[b] = '0;
      end
      for (int i = 0; i < 4; i++) hist[i] = -1000;
      last_any = -1000; mviol = 0; mvb = 0; t = 0;
      @(negedge clk);
      check_outs();        // R1 state while reset is held
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic random_run(int n);
      for (int i = 0; i < n; i++) begin
         int r = int'($urandom % 16);
         int b = int'($urandom % 8);
         int k;
         logic [13:0] row = 14'($urandom);
         k = (r < 5) ? 1 : (r < 9) ? 2 : (r < 11) ? 3 : (r < 13) ? 4 : (r == 13) ? 5 : 0;
         if ((k == 1 && !m_act_ok(b)) || ((k == 2 || k == 3) && !m_rw_ok(b)) ||
             (k == 4 && !m_pre_ok(b)) || (k == 5 && m_prea_bad() >= 0)) k = 0;
         apply(k, b, row);
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      // R1 reset state
      do_reset(3, 6, 3, 9, 2, 10, 0);
      apply(0, 0, '0);

      // R4: four back-to-back activates, window of 10, then walk to its edge
      do_reset(2, 3, 2, 5, 1, 10, 0);
      for (int b = 0; b < 4; b++) apply(1, b, 14'(16'h100 + b));
      for (int i = 0; i < 6; i++) apply(0, 0, '0);
      apply(1, 4, 14'h0abc);                 // first cycle the window admits
      for (int i = 0; i < 3; i++) apply(0, 0, '0);

      // R5: additive latency covers the column wait on the next cycle
      do_reset(4, 6, 3, 9, 2, 12, 3);
      apply(1, 6, 14'h1234);
      apply(2, 6, '0);
      apply(3, 6, '0);
      // R2: refresh code and deselected strobes change nothing
      apply(6, 1, 14'h3fff);
      apply(7, 2, 14'h2222);
      // R7: precharge-all adds one cycle to every bank's wait
      for (int i = 0; i < 6; i++) apply(0, 0, '0);
      apply(5, 0, '0);
      for (int i = 0; i < 6; i++) apply(0, 0, '0);
      apply(4, 3, '0);                       // R7 single precharge on closed bank
      for (int i = 0; i < 4; i++) apply(0, 0, '0);

      // R3/R5/R6/R8 random legal traffic, two timing sets
      do_reset(3, 6, 3, 9, 2, 10, 0);
      random_run(3000);
      do_reset(5, 8, 4, 12, 1, 6, 2);
      random_run(3000);

      // R9: read to a closed bank is recorded, later faults keep it
      do_reset(3, 6, 3, 9, 2, 10, 0);
      apply(2, 5, '0);
      apply(1, 5, 14'h0055);
      apply(1, 5, 14'h0066);
      apply(0, 0, '0);
      // R9: precharge-all with two banks inside tras reports the lower one
      do_reset(3, 6, 3, 9, 1, 10, 0);
      apply(1, 6, 14'h0006);
      apply(1, 2, 14'h0002);
      apply(5, 0, '0);
      apply(0, 0, '0);
      // R10: a rejected activate still restarts its bank's timers
      do_reset(2, 4, 2, 6, 1, 10, 0);
      apply(1, 3, 14'h0aaa);
      apply(0, 0, '0);
      apply(1, 3, 14'h0bbb);
      for (int i = 0; i < 8; i++) apply(0, 0, '0);
      apply(4, 3, '0);
      for (int i = 0; i < 4; i++) apply(0, 0, '0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements) actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule